// File: doc/BRIEF.md
# Nonvolatile SRAM Software Command Controller

This block is a clocked model of a byte-wide static RAM that sits beside a nonvolatile shadow array of equal size. Ordinary accesses use a simple active-low bus: enable, output enable and write enable, plus a 15-bit address, write data and registered read data. The full part is 32,768 bytes deep (`ARRAY_AW` = 15). The default elaboration uses a 512-byte array (`ARRAY_AW` = 9), and the address bits above the array width are then ignored for data.

A command detector watches every enable-controlled access. When it sees six reads in one fixed order with no other access between them, it starts a copy. The copy is either a STORE, which erases the shadow and then fills it from the SRAM, or a RECALL, which overwrites the SRAM from the shadow. While the copy runs, the bus is locked out and `busy` is high. The copy engine moves one byte per clock and adds parameterised erase and program delays to a STORE.

Top module: `nvsram_ctrl`

## Requirements
- R1: A read is an access with `en_n`=0, `oe_n`=0 and `we_n`=1 while not busy. On the next clock, `rdata` holds the byte at the address's low `ARRAY_AW` bits. In every other idle cycle, `rdata` is 0.
- R2: While not busy, each clock edge with `en_n`=0 and `we_n`=0 writes `wdata` into the byte at the address's low `ARRAY_AW` bits.
- R3: Reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, followed by a read at 0x0FC0, start a STORE. After the STORE, the shadow holds a snapshot of the whole SRAM.
- R4: The same five reads, followed by a read at 0x0C63, start a RECALL. The RECALL replaces every SRAM byte with the shadow contents.
- R5: `busy` rises on the clock after the sixth read's enable falling edge. It stays high for ERASE_CYC + 2^ARRAY_AW + PROG_CYC cycles for a STORE, and for 2^ARRAY_AW cycles for a RECALL.
- R6: On the sixth read and throughout busy, `rdata` is 0, bus writes are ignored and enable edges do not advance the detector.
- R7: A write, or a read at an address that does not match the expected step, aborts a partial sequence. No copy then starts and both arrays keep their contents.
- R8: A sequence read counts whatever the level of `oe_n`.
- R9: A read at 0x0E38 that breaks a partial sequence restarts the detector at step two.
- R10: One access is counted per falling edge of `en_n` as seen by the clock. An address change while `en_n` stays low is not a new step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 15 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
Two things can land on the same clock edge: the sixth sequence read, which fires a copy, and the ordinary bus read or write that the same access would otherwise perform. Later edges add bus writes and enable edges that arrive while the copy engine owns the arrays. The bench provokes both cases. It checks that the firing read returns zero, that writes and reads driven during every busy cycle leave the SRAM untouched with `rdata` at zero, and that the copy leaves both arrays exactly as a reference model predicts. The busy length is also counted cycle by cycle against the formula in R5.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int unsigned SEQ_LEN = 6;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ERASE,
    ENG_COPY,
    ENG_PROG
  } eng_state_t;

  // Shared prefix of the command sequence, indexed by step 0..4
  function automatic logic [14:0] cmd_prefix(input logic [2:0] step);
    case (step)
      3'd0:    cmd_prefix = 15'h0E38;
      3'd1:    cmd_prefix = 15'h31C7;
      3'd2:    cmd_prefix = 15'h03E0;
      3'd3:    cmd_prefix = 15'h3C1F;
      default: cmd_prefix = 15'h303F;
    endcase
  endfunction

  localparam logic [14:0] CMD_STORE  = 15'h0FC0;
  localparam logic [14:0] CMD_RECALL = 15'h0C63;

  // Number of cycles busy stays high for one copy
  function automatic int unsigned copy_cycles(input bit is_store, input int unsigned aw,
                                              input int unsigned erase_c,
                                              input int unsigned prog_c);
    copy_cycles = (1 << aw) + (is_store ? (erase_c + prog_c) : 0);
  endfunction

endpackage

// File: rtl/nvs_mem_bank.sv
module nvs_mem_bank #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_evt,
  input  logic        acc_rd,
  input  logic [14:0] addr,
  output logic        fire_store,
  output logic        fire_recall,
  output logic [2:0]  step
);
  logic [2:0] step_q, step_d;
  logic       hit_prefix, hit_first, last_step;

  assign hit_prefix = (addr == cmd_prefix(step_q));
  assign hit_first  = (addr == cmd_prefix(3'd0));
  assign last_step  = (step_q == 3'(SEQ_LEN - 1));

  always_comb begin
    step_d      = step_q;
    fire_store  = 1'b0;
    fire_recall = 1'b0;
    if (acc_evt) begin
      if (!acc_rd) begin
        step_d = 3'd0;
      end else if (last_step && addr == CMD_STORE) begin
        fire_store = 1'b1;
        step_d     = 3'd0;
      end else if (last_step && addr == CMD_RECALL) begin
        fire_recall = 1'b1;
        step_d      = 3'd0;
      end else if (!last_step && hit_prefix) begin
        step_d = step_q + 3'd1;
      end else if (hit_first) begin
        step_d = 3'd1;
      end else begin
        step_d = 3'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 3'd0;
    else        step_q <= step_d;
  end

  assign step = step_q;

  p_step_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= 3'(SEQ_LEN - 1));

  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !acc_rd) |=> step_q == 3'd0);

  p_fire_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_store, fire_recall}));
endmodule

// File: rtl/nvs_copy_engine.sv
module nvs_copy_engine
  import nvs_pkg::*;
#(
  parameter int unsigned AW        = 9,
  parameter int unsigned ERASE_CYC = 16,
  parameter int unsigned PROG_CYC  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_store,
  input  logic          start_recall,
  output logic          busy,
  output logic [AW-1:0] idx,
  output logic          shadow_we,
  output logic          sram_we
);
  localparam int unsigned CW = $clog2(ERASE_CYC + PROG_CYC + 2);
  localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

  eng_state_t    st_q;
  logic          store_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      store_q <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          cnt_q <= '0;
          idx_q <= '0;
          if (start_store) begin
            st_q    <= ENG_ERASE;
            store_q <= 1'b1;
          end else if (start_recall) begin
            st_q    <= ENG_COPY;
            store_q <= 1'b0;
          end
        end
        ENG_ERASE: begin
          if (cnt_q == CW'(ERASE_CYC - 1)) begin
            cnt_q <= '0;
            st_q  <= ENG_COPY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ENG_COPY: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) st_q <= store_q ? ENG_PROG : ENG_IDLE;
        end
        default: begin
          if (cnt_q == CW'(PROG_CYC - 1)) begin
            cnt_q <= '0;
            st_q  <= ENG_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy      = (st_q != ENG_IDLE);
  assign idx       = idx_q;
  assign shadow_we = (st_q == ENG_COPY) && store_q;
  assign sram_we   = (st_q == ENG_COPY) && !store_q;

  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start_store || start_recall)) |=> busy);

  p_no_copy_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(shadow_we || sram_we));

  p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shadow_we, sram_we}));
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned ARRAY_AW  = 9,
  parameter int unsigned ERASE_CYC = 16,
  parameter int unsigned PROG_CYC  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [14:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        busy
);
  logic                en_q;
  logic                acc_evt, bus_wr, rd_now, fire_store, fire_recall, fire_any;
  logic [2:0]          step;
  logic [ARRAY_AW-1:0] idx, a_lo;
  logic                shadow_we, sram_copy_we;
  logic [7:0]          sram_q, shadow_q, rdata_q;
  logic                sram_we_all;
  logic [ARRAY_AW-1:0] sram_waddr, sram_raddr;
  logic [7:0]          sram_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_n;
  end

  assign a_lo     = addr[ARRAY_AW-1:0];
  assign acc_evt  = !en_n && en_q && !busy;
  assign bus_wr   = !en_n && !we_n && !busy;
  assign fire_any = fire_store || fire_recall;
  assign rd_now   = !en_n && !oe_n && we_n && !busy && !fire_any;

  nvs_seq_detect u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_evt    (acc_evt),
    .acc_rd     (we_n),
    .addr       (addr),
    .fire_store (fire_store),
    .fire_recall(fire_recall),
    .step       (step)
  );

  nvs_copy_engine #(
    .AW       (ARRAY_AW),
    .ERASE_CYC(ERASE_CYC),
    .PROG_CYC (PROG_CYC)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_store (fire_store),
    .start_recall(fire_recall),
    .busy        (busy),
    .idx         (idx),
    .shadow_we   (shadow_we),
    .sram_we     (sram_copy_we)
  );

  assign sram_we_all = bus_wr || sram_copy_we;
  assign sram_waddr  = sram_copy_we ? idx : a_lo;
  assign sram_wdata  = sram_copy_we ? shadow_q : wdata;
  assign sram_raddr  = busy ? idx : a_lo;

  nvs_mem_bank #(.AW(ARRAY_AW), .DW(8)) u_sram (
    .clk  (clk),
    .we   (sram_we_all),
    .waddr(sram_waddr),
    .wdata(sram_wdata),
    .raddr(sram_raddr),
    .rdata(sram_q)
  );

  nvs_mem_bank #(.AW(ARRAY_AW), .DW(8)) u_shadow (
    .clk  (clk),
    .we   (shadow_we),
    .waddr(idx),
    .wdata(sram_q),
    .raddr(idx),
    .rdata(shadow_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= 8'h00;
    else if (rd_now) rdata_q <= sram_q;
    else             rdata_q <= 8'h00;
  end

  assign rdata = rdata_q;

  p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || fire_any) |=> rdata == 8'h00);

  p_no_fire_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire_any);

  p_fire_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_any |-> (!en_n && en_q));
endmodule

// File: tb/sim_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_nvsram_ctrl;
  localparam int unsigned AW    = 9;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned EC    = 16;
  localparam int unsigned PC    = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy;

  always #2 clk = ~clk;

  nvsram_ctrl #(.ARRAY_AW(AW), .ERASE_CYC(EC), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  int unsigned n_chk = 0, n_bad = 0;
  logic [7:0] m_sram [DEPTH];
  logic [7:0] m_shad [DEPTH];
  logic [14:0] pre [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};

  function automatic int unsigned exp_busy(input bit st);
    return st ? (EC + PC + DEPTH) : DEPTH;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One enable-controlled access lasting a single clock edge
  task automatic acc(input bit wr, input logic [14:0] a, input logic [7:0] d,
                     input bit oe_lo, output logic [7:0] r);
    @(negedge clk);
    en_n = 1'b1;
    @(negedge clk);
    en_n = 1'b0; we_n = !wr; oe_n = !oe_lo; addr = a; wdata = d;
    if (wr) m_sram[a[AW-1:0]] = d;
    @(negedge clk);
    r = rdata;
    en_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_chk(input logic [14:0] a, input string req);
    logic [7:0] r;
    acc(1'b0, a, 8'h00, 1'b1, r);
    chk(req, r, m_sram[a[AW-1:0]]);
  endtask

  task automatic run_prefix(input bit oe_lo);
    logic [7:0] r;
    for (int i = 0; i < 5; i++) acc(1'b0, pre[i], 8'h00, oe_lo, r);
  endtask

  // Count busy cycles while hammering the bus; all of it must be ignored
  task automatic measure(input logic [14:0] probe, output int unsigned n);
    n = 0;
    while (busy) begin
      n++;
      chk("R6 rdata while busy", rdata, 0);
      en_n = n[0]; we_n = n[1]; oe_n = 1'b0; addr = probe; wdata = 8'hA5;
      @(negedge clk);
    end
    en_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle_no_busy(input string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req, busy, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int unsigned n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 0);
    chk("R5 reset busy", busy, 0);
    rst_n = 1'b1;

    // Fill the array (R2) then random mix of reads and writes (R1, R2)
    for (int i = 0; i < DEPTH; i++) acc(1'b1, 15'(i), 8'($urandom), 1'b0, r);
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a = 15'($urandom);
      if (a == 15'h0E38) a = a ^ 15'h1;
      if ($urandom % 2) acc(1'b1, a, 8'($urandom), 1'b0, r);
      else begin
        acc(1'b0, a, 8'h00, 1'b1, r);
        chk("R1 random read", r, m_sram[a[AW-1:0]]);
      end
    end
    acc(1'b0, 15'h0123, 8'h00, 1'b0, r);
    chk("R1 no output enable gives zero", r, 0);

    // STORE with oe_n high (R8), sixth read returns zero (R6)
    run_prefix(1'b0);
    acc(1'b0, 15'h0FC0, 8'h00, 1'b0, r);
    chk("R6 firing read zero", r, 0);
    chk("R3 store starts busy", busy, 1);
    for (int i = 0; i < DEPTH; i++) m_shad[i] = m_sram[i];
    measure(15'h0040, n);
    chk("R5 store busy length", n, exp_busy(1'b1));
    rd_chk(15'h0040, "R6 write during store ignored");

    // Scramble SRAM, then RECALL restores the snapshot (R3, R4)
    for (int i = 0; i < DEPTH; i += 3) acc(1'b1, 15'(i), 8'($urandom), 1'b0, r);
    run_prefix(1'b1);
    acc(1'b0, 15'h0C63, 8'h00, 1'b1, r);
    chk("R6 recall firing read zero", r, 0);
    for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shad[i];
    measure(15'h0077, n);
    chk("R5 recall busy length", n, exp_busy(1'b0));
    for (int i = 0; i < DEPTH; i++) rd_chk(15'(i), "R4 R3 recall restores snapshot");

    // Abort by wrong read (R7)
    for (int i = 0; i < 3; i++) acc(1'b0, pre[i], 8'h00, 1'b1, r);
    acc(1'b0, 15'h1234, 8'h00, 1'b1, r);
    for (int i = 3; i < 5; i++) acc(1'b0, pre[i], 8'h00, 1'b1, r);
    acc(1'b0, 15'h0FC0, 8'h00, 1'b1, r);
    idle_no_busy("R7 wrong read aborts");

    // Abort by write (R7)
    for (int i = 0; i < 4; i++) acc(1'b0, pre[i], 8'h00, 1'b1, r);
    acc(1'b1, 15'h303F, 8'h5C, 1'b0, r);
    acc(1'b0, 15'h303F, 8'h00, 1'b1, r);
    acc(1'b0, 15'h0C63, 8'h00, 1'b1, r);
    idle_no_busy("R7 write aborts");
    rd_chk(15'h303F, "R7 arrays unchanged after abort");
    rd_chk(15'h0C63, "R7 arrays unchanged after abort");

    // Restart at step two on 0x0E38 (R9), ending in a RECALL
    acc(1'b0, pre[0], 8'h00, 1'b1, r);
    acc(1'b0, pre[1], 8'h00, 1'b1, r);
    acc(1'b0, pre[0], 8'h00, 1'b1, r);
    for (int i = 1; i < 5; i++) acc(1'b0, pre[i], 8'h00, 1'b1, r);
    acc(1'b0, 15'h0C63, 8'h00, 1'b1, r);
    chk("R9 restart then recall fires", busy, 1);
    for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shad[i];
    measure(15'h0100, n);
    chk("R9 recall busy length", n, exp_busy(1'b0));
    rd_chk(15'h0100, "R9 sram from shadow");

    // Enable held low: address change is not a new step (R10)
    @(negedge clk); en_n = 1'b1;
    @(negedge clk); en_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = pre[0];
    repeat (2) @(negedge clk);
    addr = pre[1];
    repeat (2) @(negedge clk);
    en_n = 1'b1;
    for (int i = 2; i < 5; i++) acc(1'b0, pre[i], 8'h00, 1'b1, r);
    acc(1'b0, 15'h0FC0, 8'h00, 1'b1, r);
    idle_no_busy("R10 held enable counts once");

    finish_run();
  end
endmodule